// File: doc/BRIEF.md
# Two-Input Two-Output Butterfly Switch Stage

This block is one switching element of a unidirectional, indirect butterfly fabric. It has two input ports and two output ports, each with a valid/ready handshake. Every packet carries a destination address and a data word. The element looks at exactly one address bit, chosen by the `STAGE` parameter, and steers the packet with it. A cleared bit keeps the packet on its own lane, so input 0 goes to output 0 and input 1 to output 1. A set bit sends it across to the other lane. A fabric serving N hosts chains log2 N such stages, and each stage consumes one bit of the address.

When both inputs target the same output in a cycle, a round-robin arbiter belonging to that output lets one through and stalls the other. The stalled packet stays on its port with valid held high. Packets headed for different outputs pass together in the same cycle. Each output has a single register slot, so a packet appears on its output port one cycle after the input handshake. The slot reloads in the same cycle it drains, so a lane can carry one packet per clock.

Top module: `bfly_switch2x2`

## Requirements
- R1: While reset is asserted and after its release, with no input traffic, both output valids are low.
- R2: A packet whose address bit `STAGE` is 0 leaves on the output with the same index as its input: input 0 to output 0, input 1 to output 1.
- R3: A packet whose address bit `STAGE` is 1 leaves on the other output: input 0 to output 1, input 1 to output 0.
- R4: When the two valid inputs target different outputs and both output slots can load, both inputs are accepted in the same cycle.
- R5: A packet accepted at a clock edge is valid on its output directly after that edge, with its address and data unchanged, and every accepted packet is delivered exactly once.
- R6: When both valid inputs target the same output, at most one of them sees ready high in that cycle.
- R7: Each output's arbiter favours input 0 after reset. After it resolves a conflict, the next conflict on the same output goes to the other input. A request without a competitor leaves the preference unchanged.
- R8: An output holding a packet with its ready low keeps valid high and address and data steady, and accepts no new packet. When the output's ready is high, a new packet can load in the same cycle the old one leaves.
- R9: Address bits other than bit `STAGE` have no effect on the route.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| in0Valid | input | 1 | Input 0 packet present |
| in0Ready | output | 1 | Input 0 packet taken at this edge |
| in0Addr | input | ADDR_W | Input 0 destination address |
| in0Data | input | DATA_W | Input 0 data word |
| in1Valid | input | 1 | Input 1 packet present |
| in1Ready | output | 1 | Input 1 packet taken at this edge |
| in1Addr | input | ADDR_W | Input 1 destination address |
| in1Data | input | DATA_W | Input 1 data word |
| out0Valid | output | 1 | Output 0 slot holds a packet |
| out0Ready | input | 1 | Downstream takes output 0 |
| out0Addr | output | ADDR_W | Output 0 address |
| out0Data | output | DATA_W | Output 0 data word |
| out1Valid | output | 1 | Output 1 slot holds a packet |
| out1Ready | input | 1 | Downstream takes output 1 |
| out1Addr | output | ADDR_W | Output 1 address |
| out1Data | output | DATA_W | Output 1 data word |

## Verification
The bench creates head-on conflicts twice in a row on one output. A design with a fixed priority or a pointer that never moves would grant input 0 both times and starve input 1. It stalls an output with a packet in its slot and then tries to load a second packet. A design that ignores backpressure would overwrite the first packet, and one that does not pass the slot through on ready would lose a cycle. It drives addresses whose other bits change while the examined bit stays fixed, and a burst with irregular output readiness. The scoreboard then catches any packet that is misrouted, duplicated or dropped, or whose address or data is corrupted.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  localparam int unsigned NUM_LANES = 2;

  // strobes from control to datapath, one bit per output lane
  typedef struct packed {
    logic [NUM_LANES-1:0] load;  // capture a packet into the output slot
    logic [NUM_LANES-1:0] sel;   // which input lane feeds the slot
  } xbarStrobe_t;

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LANES-1:0] inValid,
  input  logic [NUM_LANES-1:0] routeBit,
  input  logic [NUM_LANES-1:0] outReady,
  output logic [NUM_LANES-1:0] inReady,
  output logic [NUM_LANES-1:0] outValid,
  output xbarStrobe_t          strobe
);

  logic [NUM_LANES-1:0]                target;
  logic [NUM_LANES-1:0][NUM_LANES-1:0] req;     // req[output][input]
  logic [NUM_LANES-1:0]                win;
  logic [NUM_LANES-1:0]                loadV;
  logic [NUM_LANES-1:0]                slotFree;
  logic [NUM_LANES-1:0]                ptr;     // preferred input per output
  logic [NUM_LANES-1:0]                vld;

  // straight when the bit is 0, across when it is 1
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_target
    assign target[i] = routeBit[i] ^ 1'(i);
  end

  for (genvar o = 0; o < NUM_LANES; o++) begin : g_out
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_req
      assign req[o][i] = inValid[i] && (target[i] == 1'(o));
    end

    assign win[o]      = (req[o] == 2'b11) ? ptr[o] : req[o][1];
    assign slotFree[o] = !vld[o] || outReady[o];
    assign loadV[o]    = (|req[o]) && slotFree[o];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld[o] <= 1'b0;
        ptr[o] <= 1'b0;
      end else begin
        if (loadV[o]) begin
          vld[o] <= 1'b1;
        end else if (outReady[o]) begin
          vld[o] <= 1'b0;
        end
        if (loadV[o] && (req[o] == 2'b11)) begin
          ptr[o] <= ~win[o];
        end
      end
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
      (vld[o] && !outReady[o]) |=> vld[o]);  // R8

    AST_RR_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
      ($past(loadV[o] && (req[o] == 2'b11)) && loadV[o] && (req[o] == 2'b11))
        |-> (win[o] != $past(win[o])));  // R7
  end

  always_comb begin
    strobe.load = loadV;
    strobe.sel  = win;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_ready
    assign inReady[i] = inValid[i] && loadV[target[i]] && (win[target[i]] == 1'(i));
  end

  assign outValid = vld;

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
    (target[0] == target[1]) |-> !(inReady[0] && inReady[1]));  // R6

  AST_BOTH_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid == 2'b11 && target[0] != target[1] && slotFree == 2'b11)
      |-> (inReady == 2'b11));  // R4

endmodule

// File: rtl/bfly_dpath.sv
module bfly_dpath
  import bfly_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  xbarStrobe_t                  strobe,
  input  logic [NUM_LANES-1:0][W-1:0]  inWord,
  output logic [NUM_LANES-1:0][W-1:0]  outWord
);

  logic [NUM_LANES-1:0][W-1:0] slot;

  for (genvar o = 0; o < NUM_LANES; o++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slot[o] <= '0;
      end else if (strobe.load[o]) begin
        slot[o] <= inWord[strobe.sel[o]];
      end
    end
  end

  assign outWord = slot;

endmodule

// File: rtl/bfly_switch2x2.sv
module bfly_switch2x2
  import bfly_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned STAGE  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              in0Valid,
  output logic              in0Ready,
  input  logic [ADDR_W-1:0] in0Addr,
  input  logic [DATA_W-1:0] in0Data,
  input  logic              in1Valid,
  output logic              in1Ready,
  input  logic [ADDR_W-1:0] in1Addr,
  input  logic [DATA_W-1:0] in1Data,
  output logic              out0Valid,
  input  logic              out0Ready,
  output logic [ADDR_W-1:0] out0Addr,
  output logic [DATA_W-1:0] out0Data,
  output logic              out1Valid,
  input  logic              out1Ready,
  output logic [ADDR_W-1:0] out1Addr,
  output logic [DATA_W-1:0] out1Data
);

  localparam int unsigned PKT_W = ADDR_W + DATA_W;

  xbarStrobe_t                     strobe;
  logic [NUM_LANES-1:0]            inReadyV;
  logic [NUM_LANES-1:0]            outValidV;
  logic [NUM_LANES-1:0][PKT_W-1:0] inWord;
  logic [NUM_LANES-1:0][PKT_W-1:0] outWord;

  assign inWord[0] = {in0Addr, in0Data};
  assign inWord[1] = {in1Addr, in1Data};

  bfly_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  ({in1Valid, in0Valid}),
    .routeBit ({in1Addr[STAGE], in0Addr[STAGE]}),
    .outReady ({out1Ready, out0Ready}),
    .inReady  (inReadyV),
    .outValid (outValidV),
    .strobe   (strobe)
  );

  bfly_dpath #(.W(PKT_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inWord  (inWord),
    .outWord (outWord)
  );

  assign in0Ready  = inReadyV[0];
  assign in1Ready  = inReadyV[1];
  assign out0Valid = outValidV[0];
  assign out1Valid = outValidV[1];
  assign {out0Addr, out0Data} = outWord[0];
  assign {out1Addr, out1Data} = outWord[1];

  AST_STRAIGHT_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (in0Valid && in0Ready && !in0Addr[STAGE])
      |=> (out0Valid && out0Data == $past(in0Data) && out0Addr == $past(in0Addr)));  // R2

  AST_CROSS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (in0Valid && in0Ready && in0Addr[STAGE])
      |=> (out1Valid && out1Data == $past(in0Data) && out1Addr == $past(in0Addr)));  // R3

  AST_OUT0_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (out0Valid && !out0Ready) |=> ($stable(out0Data) && $stable(out0Addr)));  // R8

  AST_OUT1_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (out1Valid && !out1Ready) |=> ($stable(out1Data) && $stable(out1Addr)));  // R8

endmodule

// File: tb/sim_bfly_switch2x2.sv
module sim_bfly_switch2x2;

  localparam int unsigned AW = 3;
  localparam int unsigned DW = 8;
  localparam int unsigned ST = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic in0Valid = 1'b0, in1Valid = 1'b0;
  logic in0Ready, in1Ready;
  logic [AW-1:0] in0Addr = '0, in1Addr = '0;
  logic [DW-1:0] in0Data = '0, in1Data = '0;
  logic out0Valid, out1Valid;
  logic out0Ready = 1'b1, out1Ready = 1'b1;
  logic [AW-1:0] out0Addr, out1Addr;
  logic [DW-1:0] out0Data, out1Data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [AW+DW-1:0] q0[$];
  logic [AW+DW-1:0] q1[$];

  always #5 clk = ~clk;

  bfly_switch2x2 #(.ADDR_W(AW), .DATA_W(DW), .STAGE(ST)) u0 (
    .clk(clk), .rstN(rstN),
    .in0Valid(in0Valid), .in0Ready(in0Ready), .in0Addr(in0Addr), .in0Data(in0Data),
    .in1Valid(in1Valid), .in1Ready(in1Ready), .in1Addr(in1Addr), .in1Data(in1Data),
    .out0Valid(out0Valid), .out0Ready(out0Ready), .out0Addr(out0Addr), .out0Data(out0Data),
    .out1Valid(out1Valid), .out1Ready(out1Ready), .out1Addr(out1Addr), .out1Data(out1Data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard step: monitor outputs, record accepted inputs, advance one cycle
  task automatic tick();
    logic [AW+DW-1:0] exp;
    #1;
    if (out0Valid && out0Ready) begin
      if (q0.size() == 0) check(1'b0, "R5 out0 unexpected packet", {out0Addr, out0Data}, 0);
      else begin
        exp = q0.pop_front();
        check({out0Addr, out0Data} == exp, "R2 R3 R9 out0 packet", {out0Addr, out0Data}, exp);
      end
    end
    if (out1Valid && out1Ready) begin
      if (q1.size() == 0) check(1'b0, "R5 out1 unexpected packet", {out1Addr, out1Data}, 0);
      else begin
        exp = q1.pop_front();
        check({out1Addr, out1Data} == exp, "R2 R3 R9 out1 packet", {out1Addr, out1Data}, exp);
      end
    end
    if (in0Valid && in0Ready) begin
      if (in0Addr[ST]) q1.push_back({in0Addr, in0Data});
      else q0.push_back({in0Addr, in0Data});
    end
    if (in1Valid && in1Ready) begin
      if (in1Addr[ST]) q0.push_back({in1Addr, in1Data});
      else q1.push_back({in1Addr, in1Data});
    end
    @(negedge clk);
  endtask

  task automatic drive(input int port, input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (port == 0) begin in0Valid = v; in0Addr = a; in0Data = d; end
    else begin in1Valid = v; in1Addr = a; in1Data = d; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int sent0, sent1, cyc;
    @(negedge clk);
    check(out0Valid == 1'b0 && out1Valid == 1'b0, "R1 valids in reset", {out1Valid, out0Valid}, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(out0Valid == 1'b0 && out1Valid == 1'b0, "R1 valids after reset", {out1Valid, out0Valid}, 0);

    // R2 straight on input 0
    drive(0, 1'b1, 3'b000, 8'h11);
    #1 check(in0Ready == 1'b1, "R2 in0 ready", in0Ready, 1);
    tick();
    drive(0, 1'b0, '0, '0);
    #1;
    check(out0Valid && out0Data == 8'h11, "R5 straight latency out0", {out0Valid, out0Data}, {1'b1, 8'h11});
    check(out1Valid == 1'b0, "R2 out1 idle", out1Valid, 0);

    // R3 cross on input 0
    drive(0, 1'b1, 3'b010, 8'h22);
    tick();
    drive(0, 1'b0, '0, '0);
    #1;
    check(out1Valid && out1Data == 8'h22, "R3 cross to out1", {out1Valid, out1Data}, {1'b1, 8'h22});
    check(out0Valid == 1'b0, "R3 out0 drained", out0Valid, 0);
    tick();

    // R4 both straight, then both cross (R9: other bits vary)
    drive(0, 1'b1, 3'b101, 8'h33);
    drive(1, 1'b1, 3'b100, 8'h44);
    #1 check(in0Ready && in1Ready, "R4 both straight ready", {in1Ready, in0Ready}, 2'b11);
    tick();
    #1 check(out0Valid && out1Valid && out0Data == 8'h33 && out1Data == 8'h44,
             "R4 both straight delivered", {out1Data, out0Data}, {8'h44, 8'h33});
    drive(0, 1'b1, 3'b111, 8'h55);
    drive(1, 1'b1, 3'b011, 8'h66);
    #1 check(in0Ready && in1Ready, "R4 both cross ready", {in1Ready, in0Ready}, 2'b11);
    tick();
    drive(0, 1'b0, '0, '0);
    drive(1, 1'b0, '0, '0);
    #1 check(out0Data == 8'h66 && out1Data == 8'h55, "R3 R9 both cross delivered",
             {out1Data, out0Data}, {8'h55, 8'h66});
    tick();

    // R6 R7 conflict on output 0
    drive(0, 1'b1, 3'b000, 8'h77);
    drive(1, 1'b1, 3'b010, 8'h88);
    #1 check(in0Ready == 1'b1 && in1Ready == 1'b0, "R6 R7 first conflict to in0",
             {in1Ready, in0Ready}, 2'b01);
    tick();
    drive(0, 1'b1, 3'b001, 8'h99);
    #1 check(in0Ready == 1'b0 && in1Ready == 1'b1, "R7 second conflict to in1",
             {in1Ready, in0Ready}, 2'b10);
    tick();
    drive(1, 1'b0, '0, '0);
    #1 check(in0Ready == 1'b1, "R7 lone request granted", in0Ready, 1);
    tick();
    drive(0, 1'b0, '0, '0);
    tick();

    // R8 backpressure on output 0
    out0Ready = 1'b0;
    drive(0, 1'b1, 3'b000, 8'hA1);
    tick();
    drive(0, 1'b1, 3'b000, 8'hA2);
    #1 check(in0Ready == 1'b0, "R8 full slot refuses", in0Ready, 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      check(out0Valid && out0Data == 8'hA1, "R8 slot holds", {out0Valid, out0Data}, {1'b1, 8'hA1});
    end
    out0Ready = 1'b1;
    #1 check(in0Ready == 1'b1, "R8 pass-through reload", in0Ready, 1);
    tick();
    drive(0, 1'b0, '0, '0);
    #1 check(out0Valid && out0Data == 8'hA2, "R8 next packet loaded", {out0Valid, out0Data}, {1'b1, 8'hA2});
    tick();

    // burst with irregular readiness
    sent0 = 0; sent1 = 0; cyc = 0;
    while ((sent0 < 16 || sent1 < 16) && cyc < 400) begin
      out0Ready = (cyc % 3) != 0;
      out1Ready = (cyc % 5) != 1;
      drive(0, sent0 < 16, AW'(sent0), DW'(sent0));
      drive(1, sent1 < 16, AW'(~sent1), DW'(sent1 + 100));
      #1;
      if (in0Valid && in0Ready) sent0++;
      if (in1Valid && in1Ready) sent1++;
      tick();
      cyc++;
    end
    drive(0, 1'b0, '0, '0);
    drive(1, 1'b0, '0, '0);
    out0Ready = 1'b1;
    out1Ready = 1'b1;
    check(sent0 == 16 && sent1 == 16, "R4 R6 burst accepted", sent0 + sent1, 32);
    repeat (4) tick();
    check(q0.size() == 0 && q1.size() == 0, "R5 all delivered", q0.size() + q1.size(), 0);
    check(out0Valid == 1'b0 && out1Valid == 1'b0, "R5 idle after drain", {out1Valid, out0Valid}, 0);
    finishRun();
  end

endmodule